// File: doc/BRIEF.md
# Dual-Clock Receive Byte Queue with Watermark Service Request

This block carries received bytes from the serial receiver's clock domain into the system clock domain. The receiver pushes one byte per write strobe, and each byte carries a flag that marks it as the last byte of a frame. The system side pulls 16-bit words out of the queue. The first byte stored goes in the upper half of a word and the following byte goes in the lower half.

The system side is told when to fetch data through a service request. The request rises when the number of stored bytes reaches a watermark of 18, 34 or 50 bytes, chosen by a 2-bit setting. It also rises whenever a frame-ending byte is waiting in the queue, whatever the fill. A request grants one burst, and the burst length in words is programmable. The request drops when the burst has been read, when a frame-ending word has been read, or when no complete word is left. It comes back only when its trigger holds again.

With a 34-byte watermark and 8-word bursts, the first request comes at 34 bytes. Each burst removes 16 bytes, so each later request comes after 16 more bytes arrive.

If a frame ends on an odd byte, that byte is delivered alone as a final word with its lower half zero and an odd flag set. A byte pushed while the queue is full is dropped, and an overrun pulse goes back to the receiver.

Top module: `rxq_top`

## Requirements
- R1: Bytes are delivered in write order. Each word carries the earlier byte in bits [15:8] and the later byte in bits [7:0]. `rd_valid` is high for one cycle, in the cycle after the `rd_en` that removed the word.
- R2: When no burst is active, `svc_req` rises once the stored byte count reaches the watermark. The watermark is 18 bytes for `wm_sel` 0, 34 bytes for `wm_sel` 1, and 50 bytes for `wm_sel` 2 or 3. `svc_req` stays low below the watermark when no frame-ending byte is stored.
- R3: A stored byte written with `wr_eof`=1 raises `svc_req` at any fill level.
- R4: A word whose lower byte ends a frame is delivered with `rd_eof`=1 and `rd_odd`=0. A frame-ending byte that falls at a word's upper position is delivered alone as `{byte, 8'h00}` with `rd_eof`=1 and `rd_odd`=1. Only that one byte is consumed.
- R5: A burst lasts `burst_len`+1 words. `svc_req` falls in the cycle after the last word of the burst is removed, or after a frame-ending word is removed, or once no complete word is available. It rises again only when the trigger in R2 or R3 holds again.
- R6: An `rd_en` that comes when no complete word can be formed is ignored. This is the case when the queue is empty, or when it holds a single byte that does not end a frame. `rd_valid` stays 0 and no byte is consumed.
- R7: The queue holds 64 bytes. A write while it is full is dropped and the contents are left unchanged. `wr_overrun` is high for one write-clock cycle after the dropped write.
- R8: After reset, `svc_req`, `rd_valid` and `wr_overrun` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receiver-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Push one byte |
| wr_data | input | 8 | Byte to push |
| wr_eof | input | 1 | Byte ends a frame |
| wr_overrun | output | 1 | Pulse: a push was dropped because the queue was full |
| rd_clk | input | 1 | System clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| wm_sel | input | 2 | Watermark choice: 0=18, 1=34, 2/3=50 bytes |
| burst_len | input | 4 | Burst length in words minus one |
| rd_en | input | 1 | Remove one word |
| svc_req | output | 1 | Service request toward the bus master |
| rd_word | output | 16 | Word read out, earlier byte in [15:8] |
| rd_valid | output | 1 | `rd_word` holds a newly removed word |
| rd_eof | output | 1 | The word read out ends a frame |
| rd_odd | output | 1 | Only the upper byte of the word is valid |

## Verification
The assertions check the following on every cycle:
- a full-queue write never moves the write pointer and always produces an overrun pulse;
- the fill never goes above the depth;
- a pending trigger always turns into a request;
- a frame-ending word always closes its burst;
- an odd word always carries a zero lower byte with the frame-end flag;
- a read of an empty queue never yields data.

Some behaviours only the bench's scenarios can show:
- the exact watermark crossing for each setting, swept byte by byte;
- byte order and packing;
- the request re-arming 16 bytes after an 8-word burst;
- the odd-byte ending;
- the untouched contents after an overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } rxq_byte_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } rxq_state_t;

    function automatic logic [15:0] bin2gray(logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [15:0] gray2bin(logic [15:0] g);
        logic [15:0] b;
        for (int i = 0; i < 16; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

    function automatic logic [7:0] wm_bytes(logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd18;
            2'd1:    return 8'd34;
            default: return 8'd50;
        endcase
    endfunction

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  rxq_byte_t         wbyte,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output rxq_byte_t         rbyte0,
    output rxq_byte_t         rbyte1,
    output logic [DEPTH-1:0]  eof_bits
);
    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] eof_q;

    always_ff @(posedge wr_clk) begin
        if (we) data_q[waddr] <= wbyte.data;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst)  eof_q        <= '0;
        else if (we) eof_q[waddr] <= wbyte.eof;
    end

    assign rbyte0   = '{eof: eof_q[raddr0], data: data_q[raddr0]};
    assign rbyte1   = '{eof: eof_q[raddr1], data: data_q[raddr1]};
    assign eof_bits = eof_q;
endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rgray_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wgray,
    output logic              wr_overrun
);
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_n;
    logic             full;

    assign full   = (wgray == {~rgray_s[PTR_W-1:PTR_W-2], rgray_s[PTR_W-3:0]});
    assign mem_we = wr_en && !full;
    assign waddr  = wbin[ADDR_W-1:0];
    assign wbin_n = wbin + 1'b1;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin       <= '0;
            wgray      <= '0;
            wr_overrun <= 1'b0;
        end else begin
            wr_overrun <= wr_en && full;
            if (mem_we) begin
                wbin  <= wbin_n;
                wgray <= PTR_W'(bin2gray(16'(wbin_n)));
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && full) |=> $stable(wgray)); // R7
    AST_OVERRUN_PULSE: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && full) |=> wr_overrun); // R7
endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl
    import rxq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 4,
    localparam int PTR_W  = ADDR_W + 1,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic [PTR_W-1:0]   wgray_s,
    input  logic [DEPTH-1:0]   eof_bits,
    input  rxq_byte_t          rbyte0,
    input  rxq_byte_t          rbyte1,
    output logic [ADDR_W-1:0]  raddr0,
    output logic [ADDR_W-1:0]  raddr1,
    output logic [PTR_W-1:0]   rgray,
    input  logic [1:0]         wm_sel,
    input  logic [BURST_W-1:0] burst_len,
    input  logic               rd_en,
    output logic               svc_req,
    output logic [15:0]        rd_word,
    output logic               rd_valid,
    output logic               rd_eof,
    output logic               rd_odd
);
    rxq_state_t         state;
    logic [BURST_W-1:0] burst_cnt;
    logic [PTR_W-1:0]   rbin;
    logic [PTR_W-1:0]   rbin_n;
    logic [PTR_W-1:0]   wbin_s;
    logic [PTR_W-1:0]   fill;
    logic [DEPTH-1:0]   occ;
    logic               eof_pend;
    logic               word_ready;
    logic               word_eof;
    logic               pop;
    logic               trigger;

    assign wbin_s = PTR_W'(gray2bin(16'(wgray_s)));
    assign fill   = wbin_s - rbin;
    assign raddr0 = rbin[ADDR_W-1:0];
    assign raddr1 = raddr0 + 1'b1;

    // Mark which entries currently hold unread bytes.
    for (genvar i = 0; i < DEPTH; i++) begin : g_occ
        logic [ADDR_W-1:0] ofs;
        assign ofs    = ADDR_W'(i) - raddr0;
        assign occ[i] = ({1'b0, ofs} < fill);
    end

    assign eof_pend   = |(occ & eof_bits);
    assign word_ready = (fill != '0) && (rbyte0.eof || (fill >= PTR_W'(2)));
    assign word_eof   = rbyte0.eof || rbyte1.eof;
    assign pop        = rd_en && word_ready;
    assign rbin_n     = rbin + (rbyte0.eof ? PTR_W'(1) : PTR_W'(2));
    assign trigger    = (16'(fill) >= 16'(wm_bytes(wm_sel))) || eof_pend;
    assign svc_req    = (state == ST_BURST);

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
            rd_word  <= '0;
            rd_eof   <= 1'b0;
            rd_odd   <= 1'b0;
        end else begin
            rd_valid <= pop;
            if (pop) begin
                rbin    <= rbin_n;
                rgray   <= PTR_W'(bin2gray(16'(rbin_n)));
                rd_word <= rbyte0.eof ? {rbyte0.data, 8'h00} : {rbyte0.data, rbyte1.data};
                rd_eof  <= word_eof;
                rd_odd  <= rbyte0.eof;
            end
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            state     <= ST_IDLE;
            burst_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    burst_cnt <= '0;
                    if (trigger) state <= ST_BURST;
                end
                default: begin
                    if (pop) begin
                        if (burst_cnt == burst_len || word_eof) state <= ST_IDLE;
                        else burst_cnt <= burst_cnt + 1'b1;
                    end else if (!word_ready) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_FILL_BOUND: assert property (@(posedge rd_clk) disable iff (rd_rst)
        fill <= PTR_W'(DEPTH)); // R7
    AST_REQ_RISE: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!svc_req && trigger) |=> svc_req); // R2
    AST_BURST_END: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (svc_req && pop && word_eof) |=> !svc_req); // R5
    AST_NO_EMPTY_POP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && fill == '0) |=> !rd_valid); // R6
    AST_ODD_WORD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && rd_odd) |-> (rd_eof && rd_word[7:0] == 8'h00)); // R4
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 4
) (
    input  logic               wr_clk,
    input  logic               wr_rst,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               wr_eof,
    output logic               wr_overrun,
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic [1:0]         wm_sel,
    input  logic [BURST_W-1:0] burst_len,
    input  logic               rd_en,
    output logic               svc_req,
    output logic [15:0]        rd_word,
    output logic               rd_valid,
    output logic               rd_eof,
    output logic               rd_odd
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic              mem_we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr0;
    logic [ADDR_W-1:0] raddr1;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_s;
    logic [PTR_W-1:0]  rgray_s;
    logic [DEPTH-1:0]  eof_bits;
    rxq_byte_t         wbyte;
    rxq_byte_t         rbyte0;
    rxq_byte_t         rbyte1;

    assign wbyte = '{eof: wr_eof, data: wr_data};

    rxq_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
        .mem_we(mem_we), .waddr(waddr), .wgray(wgray), .wr_overrun(wr_overrun)
    );

    rxq_mem #(.ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .we(mem_we), .waddr(waddr), .wbyte(wbyte),
        .raddr0(raddr0), .raddr1(raddr1), .rbyte0(rbyte0), .rbyte1(rbyte1),
        .eof_bits(eof_bits)
    );

    rxq_sync #(.W(PTR_W)) u_sync_w2r (.clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s));
    rxq_sync #(.W(PTR_W)) u_sync_r2w (.clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s));

    rxq_rd_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_rd (
        .rd_clk(rd_clk), .rd_rst(rd_rst), .wgray_s(wgray_s), .eof_bits(eof_bits),
        .rbyte0(rbyte0), .rbyte1(rbyte1), .raddr0(raddr0), .raddr1(raddr1),
        .rgray(rgray), .wm_sel(wm_sel), .burst_len(burst_len), .rd_en(rd_en),
        .svc_req(svc_req), .rd_word(rd_word), .rd_valid(rd_valid),
        .rd_eof(rd_eof), .rd_odd(rd_odd)
    );
endmodule

// File: tb/rxq_top_test.sv
module rxq_top_test;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst = 1'b1;
    logic        rd_rst = 1'b1;
    logic        wr_en  = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_eof = 1'b0;
    logic        wr_overrun;
    logic [1:0]  wm_sel = 2'd0;
    logic [3:0]  burst_len = 4'd15;
    logic        rd_en = 1'b0;
    logic        svc_req;
    logic [15:0] rd_word;
    logic        rd_valid;
    logic        rd_eof;
    logic        rd_odd;

    int errs   = 0;
    int checks = 0;
    int cyc    = 0;

    always #5 rd_clk = ~rd_clk;
    always #7 wr_clk = ~wr_clk;

    rxq_top uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eof(wr_eof), .wr_overrun(wr_overrun), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .wm_sel(wm_sel), .burst_len(burst_len), .rd_en(rd_en), .svc_req(svc_req),
        .rd_word(rd_word), .rd_valid(rd_valid), .rd_eof(rd_eof), .rd_odd(rd_odd)
    );

    always @(posedge rd_clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic do_reset();
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        repeat (4) @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        repeat (2) @(negedge rd_clk);
    endtask

    task automatic wr_byte(input logic [7:0] d, input logic e, output logic ov);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        wr_eof  = e;
        @(negedge wr_clk);
        wr_en  = 1'b0;
        wr_eof = 1'b0;
        ov = wr_overrun;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic rd_one(output logic v, output logic [15:0] w, output logic e, output logic o);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        v = rd_valid;
        w = rd_word;
        e = rd_eof;
        o = rd_odd;
    endtask

    initial begin
        logic        ov;
        logic        v;
        logic        e;
        logic        o;
        logic [15:0] w;
        int          wm;

        do_reset();
        // R8: reset state
        chk("R8 svc_req", 32'(svc_req), 0);
        chk("R8 rd_valid", 32'(rd_valid), 0);
        chk("R8 wr_overrun", 32'(wr_overrun), 0);
        rd_one(v, w, e, o);
        chk("R8/R6 empty read", 32'(v), 0);

        // R2 watermark sweep, R1 ordering, R5 drop on starve
        for (int sel = 0; sel < 4; sel++) begin
            do_reset();
            wm_sel    = 2'(sel);
            burst_len = 4'd15;
            wm = (sel == 0) ? 18 : (sel == 1) ? 34 : 50;
            for (int n = 1; n <= wm; n++) begin
                wr_byte(pat(n - 1, sel), 1'b0, ov);
                settle();
                chk("R2 watermark", 32'(svc_req), (n >= wm) ? 1 : 0);
            end
            for (int k = 0; k < wm / 2; k++) begin
                rd_one(v, w, e, o);
                chk("R1 valid", 32'(v), 1);
                chk("R1 word", 32'(w), 32'({pat(2 * k, sel), pat(2 * k + 1, sel)}));
                chk("R4 no eof", 32'({e, o}), 0);
            end
            settle();
            chk("R5 drop after drain", 32'(svc_req), 0);
            rd_one(v, w, e, o);
            chk("R6 empty read", 32'(v), 0);
        end

        // R5 burst re-arm: 34-byte watermark, 8-word bursts
        do_reset();
        wm_sel    = 2'd1;
        burst_len = 4'd7;
        for (int n = 0; n < 34; n++) wr_byte(pat(n, 9), 1'b0, ov);
        settle();
        chk("R5 first request", 32'(svc_req), 1);
        for (int k = 0; k < 8; k++) begin
            rd_one(v, w, e, o);
            chk("R5 burst word", 32'(w), 32'({pat(2 * k, 9), pat(2 * k + 1, 9)}));
            chk("R5 req during/after burst", 32'(svc_req), (k < 7) ? 1 : 0);
        end
        settle();
        chk("R5 stays low at 18 bytes", 32'(svc_req), 0);
        for (int n = 34; n < 49; n++) wr_byte(pat(n, 9), 1'b0, ov);
        settle();
        chk("R5 low at 33 bytes", 32'(svc_req), 0);
        wr_byte(pat(49, 9), 1'b0, ov);
        settle();
        chk("R5 re-armed after 16 more bytes", 32'(svc_req), 1);

        // R3 / R4 frame ends
        do_reset();
        wm_sel    = 2'd2;
        burst_len = 4'd15;
        wr_byte(8'hA1, 1'b0, ov);
        wr_byte(8'hB2, 1'b0, ov);
        settle();
        chk("R3 no eof no req", 32'(svc_req), 0);
        wr_byte(8'hC3, 1'b1, ov);
        settle();
        chk("R3 eof raises req", 32'(svc_req), 1);
        rd_one(v, w, e, o);
        chk("R4 first word", 32'(w), 32'h0000A1B2);
        chk("R4 first flags", 32'({v, e, o}), 32'b100);
        rd_one(v, w, e, o);
        chk("R4 odd word", 32'(w), 32'h0000C300);
        chk("R4 odd flags", 32'({v, e, o}), 32'b111);
        chk("R5 eof ends burst", 32'(svc_req), 0);
        wr_byte(8'h5D, 1'b0, ov);
        wr_byte(8'h6E, 1'b1, ov);
        settle();
        chk("R3 even eof req", 32'(svc_req), 1);
        rd_one(v, w, e, o);
        chk("R4 even eof word", 32'(w), 32'h00005D6E);
        chk("R4 even eof flags", 32'({v, e, o}), 32'b110);

        // R6 lone byte not consumed
        wr_byte(8'h77, 1'b0, ov);
        settle();
        rd_one(v, w, e, o);
        chk("R6 lone byte ignored", 32'(v), 0);
        wr_byte(8'h88, 1'b0, ov);
        settle();
        rd_one(v, w, e, o);
        chk("R6 byte kept", 32'(w), 32'h00007788);
        chk("R6 valid after pair", 32'(v), 1);

        // R7 overrun
        do_reset();
        wm_sel = 2'd2;
        for (int n = 0; n < 64; n++) begin
            wr_byte(pat(n, 3), 1'b0, ov);
            if (n == 63) chk("R7 no overrun at 64", 32'(ov), 0);
        end
        settle();
        wr_byte(8'hEE, 1'b1, ov);
        chk("R7 overrun pulse", 32'(ov), 1);
        @(negedge wr_clk);
        chk("R7 pulse ends", 32'(wr_overrun), 0);
        settle();
        for (int k = 0; k < 32; k++) begin
            rd_one(v, w, e, o);
            chk("R7 contents kept", 32'({v, e, o, w}), 32'({3'b100, pat(2 * k, 3), pat(2 * k + 1, 3)}));
        end
        rd_one(v, w, e, o);
        chk("R7 dropped byte absent", 32'(v), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule